// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This block sits between an internal single-request memory port and an asynchronous external SRAM. The SRAM is reached over an 8-bit shared address/data bus and a separate 8-bit high-address output. Each access begins with a one-cycle address phase. In that phase the controller raises an address-latch strobe and puts the low address byte on the shared bus, so that an external transparent latch can hold it. The data phase follows. A write drives the data onto the shared bus under an active-low write strobe. A read releases the bus and lowers an active-low read strobe while the SRAM drives the data.

The strobe-low phase lasts one clock cycle plus a programmable number of wait states, from 0 to 3. The address space is split at a programmable high-byte threshold into a lower and an upper sector, and each sector has its own wait setting. Two devices with different access times can therefore share one bus. All timing comes from the internal clock alone.

An optional bus-keeper drives the shared bus with its last value while the controller is idle. When the keeper is disabled, the bus is left floating while idle.

Top module: `muxbus_top`

## Requirements
- R1: During the address-latch cycle the shared bus carries bits 7:0 of the request address. `addrHigh` carries bits 15:8, and it holds that value unchanged through every strobe-low cycle of the access.
- R2: `aleOut` is high for exactly one cycle per access. That cycle comes before the first strobe-low cycle, and `rdN` and `wrN` are both high while `aleOut` is high.
- R3: In a write, `wrN` is low and the shared bus carries the write data. In a read, `rdN` is low and the controller does not drive the shared bus. `rdN` and `wrN` are never low in the same cycle.
- R4: The strobe-low phase lasts exactly 1 + W clock cycles, where W (0 to 3) is the 2-bit wait setting that applies to the access.
- R5: If the request address bits 15:8 are greater than or equal to `cfgSectorLimit`, `cfgWaitUpper` applies. Otherwise `cfgWaitLower` applies. The setting is taken in the cycle the request is accepted, so changing the configuration later has no effect on that access.
- R6: A request is accepted when `reqValid` is high while the controller is idle. `reqReady` is high for exactly one cycle, the cycle after the strobe rises. Counting the latch cycle as cycle 1, that is cycle W + 3. For a read, `rspRdata` then holds the bus value sampled in the last strobe-low cycle.
- R7: After reset, `rdN` and `wrN` are high, `aleOut` and `reqReady` are low, and the shared bus is not driven while `cfgKeeperEn` is low.
- R8: With `cfgKeeperEn` high, the idle bus is driven with the last value on the bus: the address byte, the write data, or the sampled read data. With `cfgKeeperEn` low, the idle bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present; held until `reqReady` |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 8 | Write data |
| reqReady | output | 1 | One-cycle completion pulse |
| rspRdata | output | 8 | Read data, valid with `reqReady` |
| cfgSectorLimit | input | 8 | High-byte threshold of the upper sector |
| cfgWaitLower | input | 2 | Wait states for the lower sector |
| cfgWaitUpper | input | 2 | Wait states for the upper sector |
| cfgKeeperEn | input | 1 | Bus-keeper enable |
| busAd | inout | 8 | Shared address-low / data bus |
| addrHigh | output | 8 | High address byte |
| aleOut | output | 1 | Address-latch strobe, active high |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |

## Verification
The hardest situation to reach from the ports is a configuration change that lands in the middle of an access. R5 requires that the wait count already taken still governs the access. To reach it, the stimulus rewrites both wait settings on the cycle after acceptance in a random subset of accesses, and it compares the measured strobe-low length against the original setting. Addresses just below and at the sector threshold are applied directly. The bench's SRAM model is indexed only through the latched address byte and `addrHigh`, so a corrupted address phase shows up as wrong read data.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  // Control-to-datapath strobes. Pin-facing fields are registered in the
  // control; load and sample are same-cycle pulses.
  typedef struct packed {
    logic ale;        // address-latch cycle
    logic rdLow;      // read strobe asserted
    logic wrLow;      // write strobe asserted
    logic driveAddr;  // put low address byte on shared bus
    logic driveData;  // put write data on shared bus
    logic ready;      // completion cycle
    logic busIdle;    // controller idle (keeper may drive)
    logic load;       // capture request this cycle
    logic sample;     // capture read data this cycle
  } busStrobes_t;

endpackage

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
  import muxbus_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [WAIT_W-1:0] reqWait,
  output busStrobes_t       strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_STROBE, ST_DONE} state_t;

  state_t            stateQ, stateNext;
  logic [WAIT_W-1:0] cntQ, cntNext;
  logic              writeQ, writeNext;
  logic              load, sample;
  busStrobes_t       pinQ, pinNext;

  always_comb begin
    stateNext = stateQ;
    cntNext   = cntQ;
    writeNext = writeQ;
    load      = 1'b0;
    sample    = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          load      = 1'b1;
          cntNext   = reqWait;
          writeNext = reqWrite;
          stateNext = ST_ADDR;
        end
      end
      ST_ADDR: stateNext = ST_STROBE;
      ST_STROBE: begin
        if (cntQ == '0) begin
          sample    = !writeQ;
          stateNext = ST_DONE;
        end else begin
          cntNext = cntQ - 1'b1;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  // Pin strobes decoded from the next state and registered, so every
  // external strobe leaves a flop.
  always_comb begin
    pinNext           = '0;
    pinNext.ale       = (stateNext == ST_ADDR);
    pinNext.driveAddr = (stateNext == ST_ADDR);
    pinNext.rdLow     = (stateNext == ST_STROBE) && !writeNext;
    pinNext.wrLow     = (stateNext == ST_STROBE) && writeNext;
    pinNext.driveData = writeNext && ((stateNext == ST_STROBE) || (stateNext == ST_DONE));
    pinNext.ready     = (stateNext == ST_DONE);
    pinNext.busIdle   = (stateNext == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ       <= ST_IDLE;
      cntQ         <= '0;
      writeQ       <= 1'b0;
      pinQ         <= '0;
      pinQ.busIdle <= 1'b1;
    end else begin
      stateQ <= stateNext;
      cntQ   <= cntNext;
      writeQ <= writeNext;
      pinQ   <= pinNext;
    end
  end

  always_comb begin
    strb        = pinQ;
    strb.load   = load;
    strb.sample = sample;
  end

  // ---------------- assertions ----------------
  localparam int RUN_W   = WAIT_W + 2;
  localparam int RUN_MAX = 2 ** WAIT_W;

  logic [RUN_W-1:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         lowRun <= '0;
    else if (pinQ.rdLow || pinQ.wrLow) lowRun <= (lowRun == '1) ? lowRun : lowRun + 1'b1;
    else                               lowRun <= '0;
  end

  // R3: never both strobes low
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(pinQ.rdLow && pinQ.wrLow));

  // R2: strobes high while the latch strobe is high
  a_r2_ale_alone: assert property (@(posedge clk) disable iff (!rstN)
    pinQ.ale |-> !(pinQ.rdLow || pinQ.wrLow));

  // R2: a strobe falls only right after the latch cycle
  a_r2_ale_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinQ.rdLow || pinQ.wrLow) |-> $past(pinQ.ale));

  // R6: completion follows a strobe-low cycle with strobes released
  a_r6_ready_after_rise: assert property (@(posedge clk) disable iff (!rstN)
    pinQ.ready |-> ($past(pinQ.rdLow || pinQ.wrLow) && !(pinQ.rdLow || pinQ.wrLow)));

  // R6: completion lasts one cycle
  a_r6_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    pinQ.ready |=> !pinQ.ready);

  // R4: strobe-low run never exceeds 1 + maximum wait
  a_r4_strobe_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(lowRun) <= RUN_MAX);

endmodule

// File: rtl/muxbus_datapath.sv
module muxbus_datapath
  import muxbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  busStrobes_t              strb,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [ADDR_W-DATA_W-1:0] cfgSectorLimit,
  input  logic [WAIT_W-1:0]        cfgWaitLower,
  input  logic [WAIT_W-1:0]        cfgWaitUpper,
  input  logic                     cfgKeeperEn,
  input  logic [DATA_W-1:0]        busIn,
  output logic [WAIT_W-1:0]        reqWait,
  output logic [ADDR_W-DATA_W-1:0] addrHigh,
  output logic                     aleOut,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     reqReady,
  output logic [DATA_W-1:0]        rspRdata,
  output logic [DATA_W-1:0]        busOut,
  output logic                     busOe
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ, keepQ;
  logic              upperSector;

  // Sector choice on the incoming address; the control latches it on load.
  assign upperSector = (reqAddr[ADDR_W-1:DATA_W] >= cfgSectorLimit);
  assign reqWait     = upperSector ? cfgWaitUpper : cfgWaitLower;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      keepQ  <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.sample) rdataQ <= busIn;
      if (strb.driveAddr)      keepQ <= addrQ[DATA_W-1:0];
      else if (strb.driveData) keepQ <= wdataQ;
      else if (strb.sample)    keepQ <= busIn;
    end
  end

  assign addrHigh = addrQ[ADDR_W-1:DATA_W];
  assign aleOut   = strb.ale;
  assign rdN      = !strb.rdLow;
  assign wrN      = !strb.wrLow;
  assign reqReady = strb.ready;
  assign rspRdata = rdataQ;

  assign busOe  = strb.driveAddr || strb.driveData || (cfgKeeperEn && strb.busIdle);
  assign busOut = strb.driveAddr ? addrQ[DATA_W-1:0] :
                  strb.driveData ? wdataQ : keepQ;

  // ---------------- assertions ----------------
  // R3: bus released while the read strobe is low
  a_r3_release_on_read: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdLow |-> !busOe);

  // R1: high address byte steady through the strobe phase
  a_r1_high_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdLow || strb.wrLow) |-> $stable(addrHigh));

  // R8: keeper value does not drift while idle
  a_r8_keeper_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strb.busIdle && $past(strb.busIdle)) |-> $stable(busOut));

  initial begin
    a_r1_widths: assert (HI_W > 0);
  end

endmodule

// File: rtl/muxbus_top.sv
module muxbus_top
  import muxbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  output logic                     reqReady,
  output logic [DATA_W-1:0]        rspRdata,
  input  logic [ADDR_W-DATA_W-1:0] cfgSectorLimit,
  input  logic [WAIT_W-1:0]        cfgWaitLower,
  input  logic [WAIT_W-1:0]        cfgWaitUpper,
  input  logic                     cfgKeeperEn,
  inout  wire  [DATA_W-1:0]        busAd,
  output logic [ADDR_W-DATA_W-1:0] addrHigh,
  output logic                     aleOut,
  output logic                     rdN,
  output logic                     wrN
);

  busStrobes_t       strb;
  logic [WAIT_W-1:0] reqWait;
  logic [DATA_W-1:0] busOut;
  logic              busOe;

  muxbus_ctrl #(.WAIT_W(WAIT_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqWait  (reqWait),
    .strb     (strb)
  );

  muxbus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) i_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strb),
    .reqAddr        (reqAddr),
    .reqWdata       (reqWdata),
    .cfgSectorLimit (cfgSectorLimit),
    .cfgWaitLower   (cfgWaitLower),
    .cfgWaitUpper   (cfgWaitUpper),
    .cfgKeeperEn    (cfgKeeperEn),
    .busIn          (busAd),
    .reqWait        (reqWait),
    .addrHigh       (addrHigh),
    .aleOut         (aleOut),
    .rdN            (rdN),
    .wrN            (wrN),
    .reqReady       (reqReady),
    .rspRdata       (rspRdata),
    .busOut         (busOut),
    .busOe          (busOe)
  );

  assign busAd = busOe ? busOut : {DATA_W{1'bz}};

endmodule

// File: tb/test_muxbus_top.sv
module test_muxbus_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady;
  logic [7:0]  rspRdata;
  logic [7:0]  cfgSectorLimit = 8'h80;
  logic [1:0]  cfgWaitLower = 2'd0, cfgWaitUpper = 2'd3;
  logic        cfgKeeperEn = 1'b0;
  tri1  [7:0]  busAd;
  logic [7:0]  addrHigh;
  logic        aleOut, rdN, wrN;

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  // SRAM model, reached only through the latched address
  logic [7:0] sram   [0:1023];
  logic [7:0] shadow [0:1023];
  logic [7:0] latLo = '0, latHi = '0;

  assign busAd = (!rdN) ? sram[{latHi[1:0], latLo}] : 8'bz;

  always #(CLK_PERIOD/2) clk = ~clk;

  muxbus_top i_muxbus_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady), .rspRdata(rspRdata),
    .cfgSectorLimit(cfgSectorLimit), .cfgWaitLower(cfgWaitLower),
    .cfgWaitUpper(cfgWaitUpper), .cfgKeeperEn(cfgKeeperEn), .busAd(busAd),
    .addrHigh(addrHigh), .aleOut(aleOut), .rdN(rdN), .wrN(wrN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] expWait(input logic [15:0] a);
    return (a[15:8] >= cfgSectorLimit) ? cfgWaitUpper : cfgWaitLower;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  // One access; called at a negedge with the controller idle.
  task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                        input bit flipCfg);
    int lat = 0, low = 0, aleCnt = 0, aleAt = 0, firstLow = 0, both = 0;
    logic [1:0] w, savL, savU;
    logic [7:0] wrSeen = '0, rd;
    logic [7:0] hiAtStrobe = '0;
    bit hiMoved = 1'b0;
    w = expWait(a);
    savL = cfgWaitLower; savU = cfgWaitUpper;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    do begin
      @(negedge clk);
      lat++;
      if (flipCfg && lat == 1) begin
        cfgWaitLower = ~savL; cfgWaitUpper = ~savU;
      end
      if (aleOut) begin
        aleCnt++; aleAt = lat; latLo = busAd; latHi = addrHigh;
        check(rdN && wrN, "R2 strobes high during latch", {rdN, wrN}, 2'b11);
      end
      if (!rdN || !wrN) begin
        if (low == 0) begin firstLow = lat; hiAtStrobe = addrHigh; end
        else if (addrHigh != hiAtStrobe) hiMoved = 1'b1;
        low++;
      end
      if (!rdN && !wrN) both++;
      if (!wrN) wrSeen = busAd;
    end while (!reqReady && lat < 20);
    rd = rspRdata;
    reqValid = 1'b0;
    if (flipCfg) begin cfgWaitLower = savL; cfgWaitUpper = savU; end
    check(lat == int'(w) + 3, "R6 ready latency", lat, int'(w) + 3);
    check(low == int'(w) + 1, flipCfg ? "R5 wait fixed at accept" : "R4 strobe length",
          low, int'(w) + 1);
    check(aleCnt == 1 && aleAt < firstLow, "R2 single latch cycle before strobe", aleCnt, 1);
    check({latHi, latLo} == a, "R1 latched address", {latHi, latLo}, a);
    check(!hiMoved, "R1 high byte stable", hiMoved, 0);
    check(both == 0, "R3 strobes exclusive", both, 0);
    if (wr) begin
      check(wrSeen == d, "R3 write data on bus", wrSeen, d);
      sram[{latHi[1:0], latLo}] = wrSeen;
      shadow[a[9:0]] = d;
    end else begin
      check(rd == shadow[a[9:0]], "R6 read data", rd, shadow[a[9:0]]);
    end
    @(negedge clk);
    check(!reqReady, "R6 ready one cycle", reqReady, 0);
    if (cfgKeeperEn)
      check(busAd == (wr ? d : rd), "R8 keeper holds last value", busAd, wr ? d : rd);
    else
      check(busAd == 8'hFF, "R8 released when keeper off", busAd, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      sram[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R7: reset state
    check(rdN && wrN, "R7 strobes high in reset", {rdN, wrN}, 2'b11);
    check(!aleOut && !reqReady, "R7 latch and ready low", {aleOut, reqReady}, 0);
    check(busAd == 8'hFF, "R7 bus released", busAd, 8'hFF);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // Directed: lower sector no wait, upper sector three waits
    access(1'b1, 16'h1234, 8'h5A, 1'b0);
    access(1'b0, 16'h1234, 8'h00, 1'b0);
    access(1'b1, 16'h9001, 8'hC3, 1'b0);
    access(1'b0, 16'h9001, 8'h00, 1'b0);
    // R5 threshold boundary
    cfgWaitLower = 2'd1; cfgWaitUpper = 2'd2;
    access(1'b0, 16'h7FFF, 8'h00, 1'b0);
    access(1'b0, 16'h8000, 8'h00, 1'b0);
    access(1'b1, 16'h80AA, 8'h11, 1'b1);
    // R8 keeper on: write then read
    cfgKeeperEn = 1'b1;
    access(1'b1, 16'h0102, 8'h3C, 1'b0);
    access(1'b0, 16'h9001, 8'h00, 1'b0);
    cfgKeeperEn = 1'b0;
    @(negedge clk);
    check(busAd == 8'hFF, "R8 released after keeper disabled", busAd, 8'hFF);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      if (n % 25 == 0) begin
        cfgSectorLimit = 8'($urandom);
        cfgWaitLower   = 2'($urandom);
        cfgWaitUpper   = 2'($urandom);
        cfgKeeperEn    = 1'($urandom);
      end
      access(1'($urandom), 16'($urandom), 8'($urandom_range(0, 254)),
             ($urandom_range(0, 7) == 0));
    end
    finish_run();
  end

endmodule